// File: doc/BRIEF.md
# Alarm and Event Interrupt Collector

This block gathers two families of status inputs and folds them into one active-low interrupt line for a host. Alarm inputs are qualified levels. Any change of an alarm, whether it turns on or off, marks that alarm as pending. Event inputs are single-cycle pulses. Each pulse sets a sticky bit that stays set until the host reads it.

The host sees two status words through a one-cycle read strobe. Selector value 0 returns the present alarm levels. Selector value 1 returns the sticky event bits. A read acknowledges every pending source in the word that was read and leaves the other word untouched. It does so even while an alarm stays active. Per-source mask inputs keep a source off the interrupt line, but its status and pending state are still tracked.

Top module: `irq_collector`

## Requirements
- R1: While reset is asserted and after it is released, no source is pending, `irq_n` is 1 and `rd_data` is 0. The previous alarm levels reset to inactive (0).
- R2: An alarm input that goes from 0 to 1 makes that alarm pending at the same clock edge that samples the new level. `irq_n` is 0 from that edge on, unless the alarm is masked.
- R3: An alarm input that goes from 1 to 0 also makes that alarm pending, with the same timing as R2.
- R4: A read with `rd_sel`=0 clears every alarm pending flag, even when an alarm is still active. `rd_data` then carries the alarm levels in bits [N_ALARM-1:0], with the upper bits 0.
- R5: An event input that is high for one cycle sets that event's sticky bit at that clock edge. The bit stays set until it is read.
- R6: A read with `rd_sel`=1 returns the sticky event bits in bits [N_EVENT-1:0], with the upper bits 0. An event arriving in the read cycle is included. The read clears the sticky bits.
- R7: A read clears only the pending flags of the word it selects. The other word's pending flags are kept.
- R8: A mask bit of 1 stops its source from driving `irq_n`, but the source's pending or sticky state is still set. When the mask bit later drops to 0, a still-pending source drives `irq_n` low at once.
- R9: A new alarm change or event that arrives in the same cycle as the read that would clear it wins, and the source stays pending.
- R10: `irq_n` is 1 exactly when no unmasked source is pending.
- R11: `rd_data` is registered. It updates on the clock edge that samples `rd_en`=1 and holds its value while `rd_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| alarm_in | input | N_ALARM | Qualified alarm levels |
| event_in | input | N_EVENT | Event pulses, one cycle each |
| alarm_mask | input | N_ALARM | 1 keeps the alarm off the interrupt |
| event_mask | input | N_EVENT | 1 keeps the event off the interrupt |
| rd_en | input | 1 | One-cycle read strobe |
| rd_sel | input | 1 | 0 selects alarm levels, 1 selects event bits |
| rd_data | output | DATA_W | Registered read data |
| irq_n | output | 1 | Interrupt, active low |

## Verification
The bench builds the block with four alarms, three events and an eight-bit data word. With these unequal widths, the zero padding of both words and the handling of mismatched vector sizes can be observed at `rd_data`. The small source counts let directed sequences reach every alarm and event. The random phase also produces, often, reads that coincide with fresh alarm edges or event pulses, and mask changes while sources are pending.

// File: rtl/irq_collector.sv
module irq_collector #(
  parameter int N_ALARM = 8,
  parameter int N_EVENT = 8,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_ALARM-1:0] alarm_in,
  input  logic [N_EVENT-1:0] event_in,
  input  logic [N_ALARM-1:0] alarm_mask,
  input  logic [N_EVENT-1:0] event_mask,
  input  logic               rd_en,
  input  logic               rd_sel,
  output logic [DATA_W-1:0]  rd_data,
  output logic               irq_n
);

  logic [N_ALARM-1:0] alarm_q, a_pend, a_chg;
  logic [N_EVENT-1:0] e_pend;
  logic               clr_a, clr_e;
  logic [DATA_W-1:0]  word;

  assign a_chg = alarm_in ^ alarm_q;
  assign clr_a = rd_en && !rd_sel;
  assign clr_e = rd_en && rd_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_q <= '0;
      a_pend  <= '0;
      e_pend  <= '0;
    end else begin
      alarm_q <= alarm_in;
      a_pend  <= (clr_a ? '0 : a_pend) | a_chg;
      e_pend  <= (clr_e ? '0 : e_pend) | event_in;
    end
  end

  always_comb begin
    word = '0;
    if (rd_sel) word[N_EVENT-1:0] = e_pend | event_in;
    else        word[N_ALARM-1:0] = alarm_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= word;
  end

  assign irq_n = ~(|(a_pend & ~alarm_mask) | |(e_pend & ~event_mask));

  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |-> irq_n && rd_data == '0);

  p_alarm_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (a_chg != '0) |=> ((a_pend & $past(a_chg)) == $past(a_chg)));

  p_alarm_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_a && a_chg == '0) |=> a_pend == '0);

  p_event_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (event_in != '0) |=> ((e_pend & $past(event_in)) == $past(event_in)));

  p_event_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_e && event_in == '0) |=> e_pend == '0);

  p_keep_events_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_a |=> ((e_pend & $past(e_pend)) == $past(e_pend)));

  p_keep_alarms_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_e |=> ((a_pend & $past(a_pend)) == $past(a_pend)));

  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

endmodule

// File: tb/sim_irq_collector.sv
module sim_irq_collector;
  localparam int NA = 4;
  localparam int NE = 3;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NA-1:0] alarm_in = '0, alarm_mask = '0;
  logic [NE-1:0] event_in = '0, event_mask = '0;
  logic rd_en = 1'b0, rd_sel = 1'b0;
  logic [DW-1:0] rd_data;
  logic irq_n;

  int checks = 0;
  int fails = 0;
  string phase = "R1";

  always #10 clk = ~clk;

  irq_collector #(.N_ALARM(NA), .N_EVENT(NE), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .alarm_in(alarm_in), .event_in(event_in),
    .alarm_mask(alarm_mask), .event_mask(event_mask), .rd_en(rd_en),
    .rd_sel(rd_sel), .rd_data(rd_data), .irq_n(irq_n));

  // behavioural reference
  bit m_prev[NA];
  bit m_ap[NA];
  bit m_ep[NE];
  int m_rd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NA; i++) begin m_prev[i] = 0; m_ap[i] = 0; end
      for (int i = 0; i < NE; i++) m_ep[i] = 0;
      m_rd = 0;
    end else begin
      if (rd_en) begin
        m_rd = 0;
        if (rd_sel) begin
          for (int i = 0; i < NE; i++) if (m_ep[i] || event_in[i]) m_rd += (1 << i);
        end else begin
          for (int i = 0; i < NA; i++) if (alarm_in[i]) m_rd += (1 << i);
        end
      end
      for (int i = 0; i < NA; i++) begin
        if (rd_en && !rd_sel) m_ap[i] = 0;
        if (alarm_in[i] != m_prev[i]) m_ap[i] = 1;
        m_prev[i] = alarm_in[i];
      end
      for (int i = 0; i < NE; i++) begin
        if (rd_en && rd_sel) m_ep[i] = 0;
        if (event_in[i]) m_ep[i] = 1;
      end
    end
  end

  function automatic bit model_irq_n();
    bit any = 0;
    for (int i = 0; i < NA; i++) if (m_ap[i] && !alarm_mask[i]) any = 1;
    for (int i = 0; i < NE; i++) if (m_ep[i] && !event_mask[i]) any = 1;
    return !any;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic compare_model();
    check(phase, int'(irq_n), int'(model_irq_n()));
    check(phase, int'(rd_data), m_rd);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare_model();
  endtask

  task automatic do_read(bit sel);
    rd_en = 1'b1; rd_sel = sel;
    tick();
    rd_en = 1'b0;
  endtask

  initial begin : wd
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", int'(irq_n), 1);
    check("R1", int'(rd_data), 0);
    rst_n = 1'b1;
    tick(); tick();
    check("R1", int'(irq_n), 1);

    phase = "R2";
    alarm_in = 4'b0010; tick();
    check("R2", int'(irq_n), 0);
    tick();
    check("R2", int'(irq_n), 0);

    phase = "R4";
    do_read(1'b0);
    check("R4", int'(rd_data), 8'h02);
    check("R4", int'(irq_n), 1);
    tick();
    check("R11", int'(rd_data), 8'h02);

    phase = "R3";
    alarm_in = 4'b0000; tick();
    check("R3", int'(irq_n), 0);
    do_read(1'b0);
    check("R3", int'(irq_n), 1);
    check("R4", int'(rd_data), 8'h00);

    phase = "R5";
    event_in = 3'b100; tick(); event_in = '0;
    check("R5", int'(irq_n), 0);
    tick(); tick();
    check("R5", int'(irq_n), 0);
    phase = "R6";
    do_read(1'b1);
    check("R6", int'(rd_data), 8'h04);
    check("R6", int'(irq_n), 1);

    phase = "R7";
    event_in = 3'b001; tick(); event_in = '0;
    alarm_in = 4'b1000; tick();
    do_read(1'b0);
    check("R7", int'(irq_n), 0);
    do_read(1'b1);
    check("R7", int'(rd_data), 8'h01);
    check("R7", int'(irq_n), 1);

    phase = "R8";
    alarm_mask = 4'b0001;
    alarm_in = 4'b1001; tick();
    check("R8", int'(irq_n), 1);
    tick();
    alarm_mask = 4'b0000; #1;
    check("R8", int'(irq_n), 0);
    do_read(1'b0);
    check("R8", int'(rd_data), 8'h09);
    check("R8", int'(irq_n), 1);

    phase = "R9";
    rd_en = 1'b1; rd_sel = 1'b1; event_in = 3'b010; tick();
    rd_en = 1'b0; event_in = '0;
    check("R9", int'(irq_n), 0);
    check("R6", int'(rd_data), 8'h02);
    do_read(1'b1);
    check("R9", int'(irq_n), 1);
    rd_en = 1'b1; rd_sel = 1'b0; alarm_in = 4'b0001; tick();
    rd_en = 1'b0;
    check("R9", int'(irq_n), 0);
    do_read(1'b0);
    check("R9", int'(irq_n), 1);

    phase = "R10";
    for (int k = 0; k < 3000; k++) begin
      alarm_in = ($urandom_range(0, 3) == 0) ? NA'($urandom) : alarm_in;
      event_in = ($urandom_range(0, 2) == 0) ? NE'($urandom) : '0;
      if ($urandom_range(0, 15) == 0) alarm_mask = NA'($urandom);
      if ($urandom_range(0, 15) == 0) event_mask = NE'($urandom);
      rd_en = ($urandom_range(0, 3) == 0);
      rd_sel = 1'($urandom);
      tick();
    end
    rd_en = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule